// File: doc/BRIEF.md
# Gated Ratio Clock Divider Bank

This block produces a small set of divided clocks from one fast reference clock. Every output channel counts reference cycles and toggles at a programmed integer ratio of 4, 5, 6 or 8. Each channel also has its own output gate. A simple single-cycle register port gives access to two 32-bit words: a control word at byte address 0x0 and a ratio word at byte address 0x8.

Software changes a ratio in stages. It first writes the new ratio field into the ratio word. It then sets the channel's reload-request bit in the control word, and finally drives the global trigger bit from 0 to 1. Each requested channel takes on the new ratio only when its current output period ends, so no output phase is ever cut short. A read-only status bit stays set from the trigger edge until every requested channel has switched.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, all outputs are low, both register words read 0, the status bit is 0, and every channel's active ratio is 4. Enabling a channel without any reload gives 2 cycles high and 2 cycles low.
- R2: A running channel with active ratio r repeats a period of r reference cycles: high for floor(r/2) cycles, then low for the rest. Ratio 4 gives 2/2, ratio 5 gives 2/3, ratio 6 gives 3/3 and ratio 8 gives 4/4.
- R3: Writing the ratio word alone does not change any output. A staged ratio is taken on only after a control write that carries trigger bit 8 = 1 while the stored trigger bit is 0.
- R4: A reload applies only to channels whose request bit is 1 in the same control write that carries the trigger edge. Other channels keep their ratio. Writing the trigger again while it is still 1 starts no new reload.
- R5: A ratio field code other than 4, 5, 6 or 8 (for example 0, 7 or 63) is taken on as ratio 4.
- R6: A new ratio takes effect only at an output-period boundary. No high or low phase is ever shorter than 2 reference cycles.
- R7: Clearing a channel's enable bit lets the current period finish, after which the output stays low. Setting the bit again starts a fresh period that begins with a full high phase.
- R8: Control bit 12 (read-only) reads 1 from the trigger edge until every requested channel has taken on its new ratio, and reads 0 otherwise.
- R9: Control word at address 0x0: bits [7:0] request mask, bit 8 trigger, bit 12 status, bits [31:24] enables, all other bits read 0. The ratio word at address 0x8 reads back exactly what was last written.
- R10: Channel k (k = 0, 1, 2) uses field index k+1. Its request bit is k+1, its enable bit is 25+k, and its 6-bit ratio field is at bits [8(k+1)+5 : 8(k+1)] of the ratio word (channel 0 uses [13:8]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register port |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe, sampled on the rising clock edge |
| regAddr | input | ADDR_W (4) | Byte address: 0x0 control word, 0x8 ratio word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| divClk | output | NUM_CH (3) | Divided, gated clock outputs, one bit per channel |

## Verification
The bench watches the ratio change in several ways. It checks that a staged value stays inactive with no trigger edge, and that a trigger held high does not reload a second time. A design that reloads on the level of the trigger, or straight from the ratio word, would show the new period too early. It runs illegal codes (0, 7, 63) and checks that each gives ratio 4. It also runs reloads on one channel while checking that the other channels keep their periods, which catches a broken request mask or a wrong field position. A monitor records every high and low run on every output and checks the shortest of each. A design that switches ratio in mid-period, or stops on disable in the middle of a phase, would produce a run shorter than 2 cycles. Disable followed by re-enable must give a quiet output and then a full first high phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DATA_W     = 32;
  localparam int CH_MAX     = 3;          // channels the register layout can hold
  localparam int FIELD_W    = 6;          // width of one ratio field
  localparam int IDX_STRIDE = 8;          // bit stride between channel field indices
  localparam int RATIO_W    = 4;          // wide enough for the largest ratio (8)
  localparam int TRIG_BIT   = 8;
  localparam int PEND_BIT   = 12;
  localparam int ENA_BASE   = 24;
  localparam int REQ_W      = 8;
  localparam int CTRL_OFS   = 0;
  localparam int RATIO_OFS  = 8;
  localparam logic [RATIO_W-1:0] RESET_RATIO = RATIO_W'(4);

  // Strobes and levels from the register side to the counters
  typedef struct packed {
    logic                             reload;   // one-cycle trigger edge
    logic [CH_MAX-1:0]                reqMask;  // channels named by that write
    logic [CH_MAX-1:0]                enable;   // gate level per channel
    logic [CH_MAX-1:0][FIELD_W-1:0]   staged;   // staged field per channel
  } divStb_t;

  // Maps a raw field code to the ratio actually used
  function automatic logic [RATIO_W-1:0] legalRatio(input logic [FIELD_W-1:0] code);
    case (code)
      FIELD_W'(4), FIELD_W'(5), FIELD_W'(6), FIELD_W'(8): return code[RATIO_W-1:0];
      default:                                            return RESET_RATIO;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [NUM_CH-1:0] pendVec,
  output divStb_t           stb
);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] RATIO_A = ADDR_W'(RATIO_OFS);

  logic [REQ_W-1:0]  reqQ;
  logic              trigQ;
  logic [REQ_W-1:0]  enaQ;
  logic [DATA_W-1:0] ratioQ;

  logic wrCtrl, wrRatio, trigEdge;

  assign wrCtrl   = regWr && (regAddr == CTRL_A);
  assign wrRatio  = regWr && (regAddr == RATIO_A);
  assign trigEdge = wrCtrl && regWdata[TRIG_BIT] && !trigQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ   <= '0;
      trigQ  <= 1'b0;
      enaQ   <= '0;
      ratioQ <= '0;
    end else begin
      if (wrCtrl) begin
        reqQ  <= regWdata[REQ_W-1:0];
        trigQ <= regWdata[TRIG_BIT];
        enaQ  <= regWdata[ENA_BASE +: REQ_W];
      end
      if (wrRatio) ratioQ <= regWdata;
    end
  end

  // Strobe struct: field index of channel k is k+1
  always_comb begin
    stb        = '0;
    stb.reload = trigEdge;
    for (int k = 0; k < NUM_CH; k++) begin
      stb.reqMask[k] = regWdata[k+1];
      stb.enable[k]  = enaQ[k+1];
      stb.staged[k]  = ratioQ[IDX_STRIDE*(k+1) +: FIELD_W];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_A) begin
      regRdata[REQ_W-1:0]            = reqQ;
      regRdata[TRIG_BIT]             = trigQ;
      regRdata[PEND_BIT]             = |pendVec;
      regRdata[ENA_BASE +: REQ_W]    = enaQ;
    end else if (regAddr == RATIO_A) begin
      regRdata = ratioQ;
    end
  end
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStb_t           stb,
  output logic [NUM_CH-1:0] pendVec,
  output logic [NUM_CH-1:0] divClk
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic [RATIO_W-1:0] actQ, nextRatQ, cntQ;
    logic               runQ, outQ, pendQ;
    logic               lastCyc, boundary, adoptNow;
    logic [RATIO_W-1:0] cntNext, halfLen;

    assign lastCyc  = runQ && (cntQ == actQ - ONE);
    assign boundary = !runQ || lastCyc;
    assign adoptNow = pendQ && boundary;
    assign cntNext  = cntQ + ONE;
    assign halfLen  = actQ >> 1;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actQ     <= RESET_RATIO;
        nextRatQ <= RESET_RATIO;
        cntQ     <= '0;
        runQ     <= 1'b0;
        outQ     <= 1'b0;
        pendQ    <= 1'b0;
      end else begin
        // a fresh trigger edge overrides an adoption in the same cycle
        if (stb.reload && stb.reqMask[k]) begin
          pendQ    <= 1'b1;
          nextRatQ <= legalRatio(stb.staged[k]);
        end else if (adoptNow) begin
          pendQ <= 1'b0;
        end
        if (adoptNow) actQ <= nextRatQ;
        if (boundary) begin
          // period start: continue or park low, decided by the gate
          cntQ <= '0;
          runQ <= stb.enable[k];
          outQ <= stb.enable[k];
        end else begin
          cntQ <= cntNext;
          outQ <= (cntNext < halfLen);
        end
      end
    end

    assign pendVec[k] = pendQ;
    assign divClk[k]  = outQ;
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [NUM_CH-1:0] divClk
);
  divStb_t           stb;
  logic [NUM_CH-1:0] pendVec;

  clkdiv_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pendVec  (pendVec),
    .stb      (stb)
  );

  clkdiv_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .pendVec (pendVec),
    .divClk  (divClk)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic [NUM_CH-1:0] divClk,
  input divStb_t           stb,
  input logic [NUM_CH-1:0] pendVec
);
  localparam logic [ADDR_W-1:0] RATIO_A = ADDR_W'(RATIO_OFS);

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> !stb.reload); // R4

  AST_RATIO_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == RATIO_A) && $past(regWr && (regAddr == RATIO_A))
      |-> regRdata == $past(regWdata)); // R9

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rstN)
      $rose(divClk[k]) |=> divClk[k]); // R6

    AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
      $fell(divClk[k]) |=> !divClk[k]); // R6

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rstN)
      stb.reload && stb.reqMask[k] |=> pendVec[k]); // R8

    AST_NO_TRIG_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
      !stb.reload && !pendVec[k] |=> !pendVec[k]); // R3
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .divClk   (divClk),
  .stb      (stb),
  .pendVec  (pendVec)
);

// File: tb/clkdiv_bank_bench.sv
`timescale 1ns/1ps
module clkdiv_bank_bench;
  localparam int NCH = 3;
  localparam logic [31:0] ENA_ALL = 32'h0E00_0000;
  localparam logic [31:0] TRIG    = 32'h0000_0100;

  // {channel, field code, expected high, expected low}
  localparam int NVEC = 10;
  localparam int VEC [NVEC][4] = '{
    '{0, 5, 2, 3}, '{0, 6, 3, 3}, '{1, 8, 4, 4}, '{2, 6, 3, 3}, '{0, 8, 4, 4},
    '{1, 5, 2, 3}, '{0, 7, 2, 2}, '{2, 0, 2, 2}, '{1, 63, 2, 2}, '{0, 4, 2, 2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NCH-1:0] divClk;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  int curH [NCH];
  int curL [NCH];

  always #2.5 clk = ~clk;

  clkdiv_bank u_clkdiv_bank (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .divClk(divClk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Measures the first complete high run and the following low run
  task automatic measure(input int ch, output int h, output int l);
    int g;
    h = 0; l = 0;
    g = 0;
    while (divClk[ch] !== 1'b0 && g < 64) begin @(negedge clk); g++; end
    g = 0;
    while (divClk[ch] !== 1'b1 && g < 64) begin @(negedge clk); g++; end
    while (divClk[ch] === 1'b1 && h < 64) begin h++; @(negedge clk); end
    while (divClk[ch] === 1'b0 && l < 64) begin l++; @(negedge clk); end
  endtask

  // Run-length monitor for the shortest high and low phases
  int minH = 999, minL = 999;
  int runLen [NCH];
  logic prevS [NCH];
  bit seen [NCH];
  initial for (int k = 0; k < NCH; k++) begin runLen[k] = 0; prevS[k] = 1'b0; seen[k] = 1'b0; end
  always @(negedge clk) begin
    if (rstN) begin
      for (int k = 0; k < NCH; k++) begin
        if (divClk[k] == prevS[k]) runLen[k]++;
        else begin
          if (seen[k]) begin
            if (prevS[k]) begin if (runLen[k] < minH) minH = runLen[k]; end
            else begin if (runLen[k] < minL) minL = runLen[k]; end
          end
          if (divClk[k]) seen[k] = 1'b1;
          runLen[k] = 1;
        end
        prevS[k] = divClk[k];
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, l, highs, rises;
    logic pv;
    for (int k = 0; k < NCH; k++) begin curH[k] = 2; curL[k] = 2; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h0, d); check(d == 32'h0, "R1 control after reset", int'(d), 0);
    rd(4'h8, d); check(d == 32'h0, "R1 ratio after reset", int'(d), 0);
    highs = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); highs += $countones(divClk); end
    check(highs == 0, "R1 outputs low after reset", highs, 0);

    // R1/R10: enable channel 0 only (bit 25)
    wr(4'h0, 32'h0200_0000);
    measure(0, h, l);
    check(h == 2 && l == 2, "R1 default ratio 4 high", h, 2);
    check(l == 2, "R1 default ratio 4 low", l, 2);
    highs = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); highs += int'(divClk[1]) + int'(divClk[2]); end
    check(highs == 0, "R10 enable bit 25 gates only channel 0", highs, 0);

    wr(4'h0, ENA_ALL);
    idle(10);

    // Vector table: R2 R5 R4 R10
    for (int v = 0; v < NVEC; v++) begin
      int ch, code;
      logic [31:0] req;
      ch = VEC[v][0]; code = VEC[v][1];
      req = 32'h1 << (ch + 1);
      wr(4'h8, 32'(code) << (8 * (ch + 1)));
      wr(4'h0, ENA_ALL | req);
      wr(4'h0, ENA_ALL | req | TRIG);
      wr(4'h0, ENA_ALL);
      curH[ch] = VEC[v][2]; curL[ch] = VEC[v][3];
      idle(20);
      for (int k = 0; k < NCH; k++) begin
        measure(k, h, l);
        if (k == ch) begin
          check(h == curH[k], $sformatf("R2 R5 vec%0d ch%0d code %0d high", v, k, code), h, curH[k]);
          check(l == curL[k], $sformatf("R2 R5 vec%0d ch%0d code %0d low", v, k, code), l, curL[k]);
        end else begin
          check(h == curH[k] && l == curL[k],
                $sformatf("R4 R10 vec%0d untouched ch%0d high", v, k), h, curH[k]);
        end
      end
    end

    // R8 status bit 12: ch0 from 4 to 8
    wr(4'h8, 32'h0000_0800);
    wr(4'h0, ENA_ALL | 32'h2 | TRIG);
    rd(4'h0, d); pv = d[12];
    check(pv == 1'b1, "R8 status set after trigger edge", int'(pv), 1);
    idle(20);
    rd(4'h0, d); pv = d[12];
    check(pv == 1'b0, "R8 status clear after adoption", int'(pv), 0);
    wr(4'h0, ENA_ALL);
    measure(0, h, l);
    check(h == 4 && l == 4, "R8 ratio 8 adopted", h, 4);

    // R3: ratio word alone has no effect
    wr(4'h8, 32'h0000_0600);
    idle(20);
    measure(0, h, l);
    check(h == 4 && l == 4, "R3 staged ratio not applied without trigger", h, 4);
    wr(4'h0, ENA_ALL | 32'h2 | TRIG);
    idle(20);
    measure(0, h, l);
    check(h == 3 && l == 3, "R3 staged ratio applied on trigger edge", h, 3);

    // R4: trigger held high does not reload
    wr(4'h8, 32'h0000_0500);
    wr(4'h0, ENA_ALL | 32'h2 | TRIG);
    idle(20);
    measure(0, h, l);
    check(h == 3 && l == 3, "R4 held trigger starts no reload", h, 3);
    wr(4'h0, ENA_ALL);
    wr(4'h0, ENA_ALL | 32'h2 | TRIG);
    wr(4'h0, ENA_ALL);
    idle(20);
    measure(0, h, l);
    check(h == 2, "R4 new edge reloads ratio 5 high", h, 2);
    check(l == 3, "R4 new edge reloads ratio 5 low", l, 3);

    // R7: disable ch0, then re-enable
    wr(4'h0, 32'h0C00_0000);
    idle(12);
    highs = 0; rises = 0;
    for (int i = 0; i < 30; i++) begin
      logic p1;
      p1 = divClk[1];
      @(negedge clk);
      highs += int'(divClk[0]);
      if (!p1 && divClk[1]) rises++;
    end
    check(highs == 0, "R7 disabled channel stays low", highs, 0);
    check(rises > 0, "R7 other channels keep running", rises, 1);
    wr(4'h0, ENA_ALL);
    measure(0, h, l);
    check(h == 2 && l == 3, "R7 re-enable starts full period", h, 2);

    // R9 register map readback
    wr(4'h8, 32'h1234_5678);
    rd(4'h8, d); check(d == 32'h1234_5678, "R9 ratio word readback", int'(d), 32'h1234_5678);
    wr(4'h0, 32'h0E01_F0A5);
    rd(4'h0, d); check(d == 32'h0E00_00A5, "R9 control readback masks bits", int'(d), 32'h0E00_00A5);

    // R6 shortest observed phases
    check(minH == 2, "R6 shortest high phase", minH, 2);
    check(minL == 2, "R6 shortest low phase", minL, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule